// File: doc/BRIEF.md
# Dot-Matrix Scan Timing and Address Generator

This block produces the scan timing and the video-RAM read address for a 128 x 32 monochrome dot-matrix panel. A video tick, derived from the system clock, steps a per-row timer. The first part of each row shifts out dots on a dot clock. The remainder of the row is a column-latch window. A scan group is four 32-row frames. At the end of each group the block raises a one-cycle interrupt toward the display CPU.

Four small control registers are written through a plain write port: a column start, a row start, a control byte holding plane enable and sync select, and a code page. The read address is built from four fields, and each field has its own reload point. The column field is reloaded at every row end. The row and plane fields are reloaded at every group end. The page field follows its register with no reload timing. A static mode input selects between two board generations. They differ in video-clock division, in sync gating and in the source of the plane field. The mode input is changed only while reset is held.

Top module: `dmd_scan_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, ram_addr is 0, irq is 0, dot_clk is 0 and col_latch is 0. Sync select resets to 1 and every other register resets to 0.
- R2: A row lasts 2*DOTS+LATCH_TICKS video ticks (384 at defaults). dot_clk is high on the odd ticks among the first 2*DOTS ticks. col_latch is high for the last LATCH_TICKS ticks. The two are never high together.
- R3: irq is a one-cycle pulse. It appears in the clock after the video tick that ends the last row of a group. A group is 4*ROWS rows (128 at defaults).
- R4: With gen_sel=0 a video tick occurs on every clock. With gen_sel=1 and sync select set, a video tick occurs on every CLK_DIV-th clock (4 at defaults). The irq period is therefore 49152 clocks in mode 0 and 196608 clocks in mode 1 at defaults.
- R5: The column field ram_addr[COL_W-1:0] (A3..A0) is loaded from column-start bits [COL_W+2:3] (bits 6..3) at every row end. Column-start bits 2..0 have no effect. Within the dot phase the field increments after every 16 ticks (8 dots), wrapping within its width.
- R6: The row field ram_addr[COL_W+ROW_W-1:COL_W] (A8..A4) is loaded from row-start bits [ROW_W-1:0] at every group end. At every other row end it increments by one. With planes off it wraps within its own width, so the same frame is scanned four times.
- R7: The plane field (A10..A9) is loaded at group end. It becomes 0 when plane enable is 0. When plane enable is 1, it takes row-start bits 7..6 in mode 0 and the constant 01 in mode 1. While planes are on, the row field carries into the plane field, so four distinct frames are scanned. The plane enable bit is sampled only at group end.
- R8: The page field ram_addr[ADDR_W-1 -: PAGE_W] (A14..A11) equals the page register and changes in the clock after its write.
- R9: In mode 1, clearing sync select freezes the timer and the address fields, and no irq occurs. In mode 0, sync select has no effect.
- R10: Write select encodings are: 0 = column start (data[6:3] at defaults); 1 = row start (data[4:0] row, data[7:6] plane); 2 = control (data[0] plane enable, data[1] sync select); 3 = code page (data[3:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_sel | input | 1 | Board generation: 0 undivided video clock, 1 divided and sync-gated |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| ram_addr | output | ADDR_W (15) | Video-RAM read address {page, plane, row, column} |
| dot_clk | output | 1 | Dot shift clock |
| col_latch | output | 1 | Column latch window |
| irq | output | 1 | End-of-group interrupt pulse |

## Verification
A slip in the per-row tick counter shows within one row. dot_clk would change phase, or col_latch would open early, and the column field would be reloaded off the row boundary. A wrong group counter or plane carry stays hidden longer. It shows only at the next row end as a bad row or plane field, and only at the next group end as a shifted irq. For that reason the bench compares all address fields every cycle and also measures whole irq periods. A divider or sync-gate fault stretches or stops every tick, so it appears within CLK_DIV clocks as frozen or racing outputs.

// File: rtl/dmd_scan_pkg.sv
package dmd_scan_pkg;
  localparam int PLANE_W    = 2;
  localparam int BYTE_DOTS  = 8;
  localparam int GRP_FRAMES = 4;
  localparam logic [PLANE_W-1:0] DIVIDED_PLANE = 2'b01;

  typedef enum logic [1:0] {
    SEL_COLSTART = 2'd0,
    SEL_ROWSTART = 2'd1,
    SEL_CTRL     = 2'd2,
    SEL_PAGE     = 2'd3
  } reg_sel_e;

  typedef enum logic {
    GEN_DIRECT  = 1'b0,
    GEN_DIVIDED = 1'b1
  } board_gen_e;
endpackage

// File: rtl/dmd_ctl_regs.sv
module dmd_ctl_regs
  import dmd_scan_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int ROW_W  = 5,
  parameter int PAGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [7:0]         wr_data,
  output logic [COL_W-1:0]   col_base,
  output logic [ROW_W-1:0]   row_base,
  output logic [PLANE_W-1:0] plane_src,
  output logic               plane_en,
  output logic               sync_sel,
  output logic [PAGE_W-1:0]  page
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_base  <= '0;
      row_base  <= '0;
      plane_src <= '0;
      plane_en  <= 1'b0;
      sync_sel  <= 1'b1;
      page      <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_COLSTART: col_base <= wr_data[COL_W+2:3];
        SEL_ROWSTART: begin
          row_base  <= wr_data[ROW_W-1:0];
          plane_src <= wr_data[7:6];
        end
        SEL_CTRL: begin
          plane_en <= wr_data[0];
          sync_sel <= wr_data[1];
        end
        default: page <= wr_data[PAGE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/dmd_vclk_div.sv
module dmd_vclk_div
  import dmd_scan_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_sel,
  input  logic sync_sel,
  output logic tick_en
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] pre_q;
  logic             run;

  assign run = (board_gen_e'(gen_sel) == GEN_DIVIDED) && sync_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_q <= '0;
    else if (run)
      pre_q <= (pre_q == DIV_LAST) ? '0 : pre_q + DIV_W'(1);
  end

  assign tick_en = (board_gen_e'(gen_sel) == GEN_DIVIDED) ? (run && pre_q == DIV_LAST) : 1'b1;
endmodule

// File: rtl/dmd_scan_timer.sv
module dmd_scan_timer
  import dmd_scan_pkg::*;
#(
  parameter int DOTS        = 128,
  parameter int LATCH_TICKS = 128,
  parameter int ROWS        = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic dot_clk,
  output logic col_latch,
  output logic byte_adv,
  output logic row_end,
  output logic group_end,
  output logic irq
);
  localparam int DOT_TICKS  = 2 * DOTS;
  localparam int ROW_TICKS  = DOT_TICKS + LATCH_TICKS;
  localparam int GRP_ROWS   = ROWS * GRP_FRAMES;
  localparam int TICK_W     = $clog2(ROW_TICKS);
  localparam int GRP_W      = $clog2(GRP_ROWS);
  localparam int BYTE_W     = $clog2(2 * BYTE_DOTS);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(ROW_TICKS - 1);
  localparam logic [TICK_W-1:0] DOT_LIM   = TICK_W'(DOT_TICKS);
  localparam logic [GRP_W-1:0]  LAST_ROW  = GRP_W'(GRP_ROWS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [GRP_W-1:0]  row_q;
  logic              in_dots;
  logic              irq_q;

  assign in_dots   = tick_q < DOT_LIM;
  assign row_end   = tick_en && (tick_q == LAST_TICK);
  assign group_end = row_end && (row_q == LAST_ROW);
  assign byte_adv  = tick_en && in_dots && (tick_q[BYTE_W-1:0] == {BYTE_W{1'b1}});
  assign dot_clk   = in_dots && tick_q[0];
  assign col_latch = !in_dots;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      row_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= group_end;
      if (tick_en) begin
        if (row_end) begin
          tick_q <= '0;
          row_q  <= (row_q == LAST_ROW) ? '0 : row_q + GRP_W'(1);
        end else begin
          tick_q <= tick_q + TICK_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dmd_addr_gen.sv
module dmd_addr_gen
  import dmd_scan_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int ROW_W  = 5,
  parameter int PAGE_W = 4,
  localparam int ADDR_W = COL_W + ROW_W + PLANE_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gen_sel,
  input  logic               byte_adv,
  input  logic               row_end,
  input  logic               group_end,
  input  logic [COL_W-1:0]   col_base,
  input  logic [ROW_W-1:0]   row_base,
  input  logic [PLANE_W-1:0] plane_src,
  input  logic               plane_en,
  input  logic [PAGE_W-1:0]  page,
  output logic [ADDR_W-1:0]  addr
);
  localparam int FR_W = ROW_W + PLANE_W;

  logic [COL_W-1:0]   col_q;
  logic [ROW_W-1:0]   row_q;
  logic [PLANE_W-1:0] plane_q;
  logic               planes_on_q;
  logic [FR_W-1:0]    frame_next;

  assign frame_next = {plane_q, row_q} + FR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      col_q <= '0;
    else if (row_end)
      col_q <= col_base;
    else if (byte_adv)
      col_q <= col_q + COL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q       <= '0;
      plane_q     <= '0;
      planes_on_q <= 1'b0;
    end else if (group_end) begin
      row_q       <= row_base;
      planes_on_q <= plane_en;
      if (!plane_en)
        plane_q <= '0;
      else if (board_gen_e'(gen_sel) == GEN_DIVIDED)
        plane_q <= DIVIDED_PLANE;
      else
        plane_q <= plane_src;
    end else if (row_end) begin
      if (planes_on_q)
        {plane_q, row_q} <= frame_next;
      else
        row_q <= row_q + ROW_W'(1);
    end
  end

  assign addr = {page, plane_q, row_q, col_q};
endmodule

// File: rtl/dmd_scan_gen.sv
module dmd_scan_gen
  import dmd_scan_pkg::*;
#(
  parameter int DOTS        = 128,
  parameter int LATCH_TICKS = 128,
  parameter int ROWS        = 32,
  parameter int CLK_DIV     = 4,
  parameter int PAGE_W      = 4,
  localparam int COL_W  = $clog2(DOTS / BYTE_DOTS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = COL_W + ROW_W + PLANE_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              dot_clk,
  output logic              col_latch,
  output logic              irq
);
  logic [COL_W-1:0]   col_base;
  logic [ROW_W-1:0]   row_base;
  logic [PLANE_W-1:0] plane_src;
  logic               plane_en;
  logic               sync_sel;
  logic [PAGE_W-1:0]  page;
  logic               tick_en;
  logic               byte_adv;
  logic               row_end;
  logic               group_end;

  dmd_ctl_regs #(.COL_W(COL_W), .ROW_W(ROW_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .col_base(col_base), .row_base(row_base), .plane_src(plane_src),
    .plane_en(plane_en), .sync_sel(sync_sel), .page(page)
  );

  dmd_vclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .sync_sel(sync_sel), .tick_en(tick_en)
  );

  dmd_scan_timer #(.DOTS(DOTS), .LATCH_TICKS(LATCH_TICKS), .ROWS(ROWS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dot_clk(dot_clk),
    .col_latch(col_latch), .byte_adv(byte_adv), .row_end(row_end),
    .group_end(group_end), .irq(irq)
  );

  dmd_addr_gen #(.COL_W(COL_W), .ROW_W(ROW_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .byte_adv(byte_adv),
    .row_end(row_end), .group_end(group_end), .col_base(col_base),
    .row_base(row_base), .plane_src(plane_src), .plane_en(plane_en),
    .page(page), .addr(ram_addr)
  );
endmodule

// File: rtl/dmd_scan_gen_chk.sv
module dmd_scan_gen_chk #(
  parameter int COL_W  = 4,
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_sel,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              dot_clk,
  input logic              col_latch,
  input logic              irq,
  input logic              row_end,
  input logic              sync_sel,
  input logic [COL_W-1:0]  col_base
);
  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_after_row_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(row_end));

  p_phase_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_latch |-> !dot_clk);

  p_col_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> ram_addr[COL_W-1:0] == $past(col_base));

  p_page_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ram_addr[ADDR_W-1 -: PAGE_W] == $past(wr_data[PAGE_W-1:0]));

  p_sync_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_sel && !sync_sel) |=> ($stable(ram_addr[ADDR_W-PAGE_W-1:0]) && !irq));
endmodule

bind dmd_scan_gen dmd_scan_gen_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .ram_addr(ram_addr), .dot_clk(dot_clk), .col_latch(col_latch),
  .irq(irq), .row_end(row_end), .sync_sel(sync_sel), .col_base(col_base)
);

// File: tb/dmd_scan_gen_tb.sv
module dmd_scan_gen_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int DOTS        = 32;
  localparam int LATCH_TICKS = 16;
  localparam int ROWS        = 8;
  localparam int CLK_DIV     = 4;
  localparam int PAGE_W      = 4;
  localparam int COL_W       = $clog2(DOTS / 8);
  localparam int ROW_W       = $clog2(ROWS);
  localparam int ADDR_W      = COL_W + ROW_W + 2 + PAGE_W;
  localparam int DOT_TICKS   = 2 * DOTS;
  localparam int ROW_TICKS   = DOT_TICKS + LATCH_TICKS;
  localparam int GRP_ROWS    = 4 * ROWS;
  localparam int NCOL        = 1 << COL_W;
  localparam int NROW        = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [ADDR_W-1:0] ram_addr;
  logic dot_clk, col_latch, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit checking = 1'b0;

  // reference state
  int m_pre, m_tick, m_grow, m_col, m_rowf, m_plane, m_page, m_cs, m_rs;
  bit m_pon, m_pen, m_sync, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmd_scan_gen #(.DOTS(DOTS), .LATCH_TICKS(LATCH_TICKS), .ROWS(ROWS),
                 .CLK_DIV(CLK_DIV), .PAGE_W(PAGE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ram_addr(ram_addr), .dot_clk(dot_clk),
    .col_latch(col_latch), .irq(irq)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      if (n_fail >= 40) finish_run();
    end
  endtask

  // reference model built from the requirements
  always @(posedge clk) begin : model
    bit en, re, ge;
    int fr;
    if (!rst_n) begin
      m_pre = 0; m_tick = 0; m_grow = 0; m_col = 0; m_rowf = 0; m_plane = 0;
      m_page = 0; m_cs = 0; m_rs = 0; m_pon = 0; m_pen = 0; m_sync = 1; m_irq = 0;
    end else begin
      en = gen_sel ? (m_sync && m_pre == CLK_DIV - 1) : 1'b1;
      re = en && (m_tick == ROW_TICKS - 1);
      ge = re && (m_grow == GRP_ROWS - 1);
      m_irq = ge;
      if (re) m_col = (m_cs >> 3) % NCOL;
      else if (en && m_tick < DOT_TICKS && (m_tick % 16) == 15) m_col = (m_col + 1) % NCOL;
      if (ge) begin
        m_rowf = m_rs % NROW;
        m_pon = m_pen;
        m_plane = !m_pen ? 0 : (gen_sel ? 1 : ((m_rs >> 6) & 3));
      end else if (re) begin
        if (m_pon) begin
          fr = (m_plane * NROW + m_rowf + 1) % (4 * NROW);
          m_plane = fr / NROW;
          m_rowf = fr % NROW;
        end else begin
          m_rowf = (m_rowf + 1) % NROW;
        end
      end
      if (en) begin
        m_tick = re ? 0 : m_tick + 1;
        if (re) m_grow = (m_grow + 1) % GRP_ROWS;
      end
      if (gen_sel && m_sync) m_pre = (m_pre + 1) % CLK_DIV;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_cs = wr_data;
          2'd1: m_rs = wr_data;
          2'd2: begin m_pen = wr_data[0]; m_sync = wr_data[1]; end
          default: m_page = wr_data[3:0];
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk(int'(ram_addr[COL_W-1:0]) == m_col, "R5 column field", int'(ram_addr[COL_W-1:0]), m_col);
      chk(int'(ram_addr[COL_W +: ROW_W]) == m_rowf, "R6 row field", int'(ram_addr[COL_W +: ROW_W]), m_rowf);
      chk(int'(ram_addr[COL_W+ROW_W +: 2]) == m_plane, "R7 plane field", int'(ram_addr[COL_W+ROW_W +: 2]), m_plane);
      chk(int'(ram_addr[ADDR_W-1 -: PAGE_W]) == m_page, "R8 page field", int'(ram_addr[ADDR_W-1 -: PAGE_W]), m_page);
      chk(dot_clk == (m_tick < DOT_TICKS && (m_tick % 2) == 1), "R2 dot_clk", int'(dot_clk), int'(m_tick < DOT_TICKS && (m_tick % 2) == 1));
      chk(col_latch == (m_tick >= DOT_TICKS), "R2 col_latch", int'(col_latch), int'(m_tick >= DOT_TICKS));
      chk(irq == m_irq, "R3 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic g);
    checking = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0; gen_sel = g;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ram_addr == '0 && !irq && !dot_clk && !col_latch, "R1 outputs in reset",
        int'(ram_addr), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_addr == '0 && !irq && !dot_clk && !col_latch, "R1 outputs after reset",
        int'(ram_addr), 0);
    checking = 1'b1;
  endtask

  task automatic random_writes(input int n, input bit keep_sync);
    for (int i = 0; i < n; i++) begin
      logic [1:0] s;
      logic [7:0] d;
      repeat ($urandom_range(20, 200)) @(posedge clk);
      s = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (s == 2'd2 && keep_sync) d[1] = 1'b1;
      wr(s, d);
    end
  endtask

  task automatic irq_period(output int n);
    int guard = 0;
    @(negedge clk);
    while (!irq && guard < 30000) begin @(negedge clk); guard++; end
    n = 0;
    @(negedge clk);
    n = 1;
    while (!irq && n < 30000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int per;
    logic [ADDR_W-1:0] held;
    bit frozen;
    void'($urandom(32'h2c0a_71e3));

    // mode 0: direct video clock
    do_reset(1'b0);
    wr(2'd2, 8'h03);                    // planes on, sync on (R10)
    wr(2'd1, 8'hC5);                    // plane source 3, row 5
    wr(2'd0, 8'h18);                    // column base 3
    random_writes(40, 1'b0);
    irq_period(per);
    chk(per == ROW_TICKS * GRP_ROWS, "R3 irq period mode 0", per, ROW_TICKS * GRP_ROWS);

    // sync select has no effect in mode 0 (R9)
    wr(2'd2, 8'h00);
    irq_period(per);
    chk(per == ROW_TICKS * GRP_ROWS, "R9 mode 0 ignores sync", per, ROW_TICKS * GRP_ROWS);

    // page follows its register on the next clock (R8)
    wr(2'd3, 8'h0B);
    @(negedge clk);
    chk(ram_addr[ADDR_W-1 -: PAGE_W] == 4'hB, "R8 page write", int'(ram_addr[ADDR_W-1 -: PAGE_W]), 11);
    wr(2'd3, 8'hF4);
    @(negedge clk);
    chk(ram_addr[ADDR_W-1 -: PAGE_W] == 4'h4, "R8 page write", int'(ram_addr[ADDR_W-1 -: PAGE_W]), 4);

    // column base low bits ignored (R5): only bits above 2 matter
    wr(2'd0, 8'h07);
    random_writes(10, 1'b0);

    // mode 1: divided video clock
    do_reset(1'b1);
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h8A);
    random_writes(60, 1'b1);
    wr(2'd2, 8'h03);
    irq_period(per);
    chk(per == CLK_DIV * ROW_TICKS * GRP_ROWS, "R4 irq period mode 1", per, CLK_DIV * ROW_TICKS * GRP_ROWS);

    // sync off freezes scanning in mode 1 (R9)
    wr(2'd2, 8'h01);
    @(negedge clk);
    held = ram_addr;
    frozen = 1'b1;
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (irq || ram_addr != held || dot_clk != u_dut.dot_clk) frozen = 1'b0;
    end
    chk(frozen, "R9 sync off freezes mode 1", int'(ram_addr), int'(held));
    wr(2'd2, 8'h02);                    // resume, planes off
    random_writes(30, 1'b1);
    irq_period(per);
    chk(per == CLK_DIV * ROW_TICKS * GRP_ROWS, "R4 irq period after resume", per, CLK_DIV * ROW_TICKS * GRP_ROWS);

    finish_run();
  end
endmodule